// File: doc/BRIEF.md
# Two-Channel Interleaved First-Order Recursive Filter

This block computes the first-order recursion y = a*y_prev + x for two independent sample streams that share one multiplier and one adder. The feedback loop holds two registers. One sits at the adder output and holds the newest result. The other sits between the multiplier and the adder and holds the scaled state of the other channel. No path from register to register therefore passes through both the multiplier and the adder, and the clock period is set by the slower of the two. The loop holds two results in flight. Each of them belongs to a different channel, so the two channels must take turns slot by slot.

The caller presents at most one sample per clock with a one-bit channel tag. After reset the first sample must belong to channel 0, and every accepted sample must then come from the other channel than the one before it. A sample whose tag breaks this order is dropped and raises a flag that stays set until reset. Idle clocks freeze the loop, so a gap of any length leaves both channel states as they were. Each result appears one clock after its sample is accepted and carries that sample's channel tag. The coefficient is a signed fraction. It is held constant while samples are flowing and is changed only while the block is idle or in reset.

Top module: `iir2_interleaved`

## Requirements
- R1: While reset is active and after it ends, out_valid and chan_err are 0, and both channel states are zero, so the first result of each channel equals its input sample.
- R2: A sample accepted at a rising edge produces out_valid = 1 after that edge, with out_chan equal to the sample's tag and out_data equal to its result. With no accepted sample at an edge, out_valid is 0 after that edge.
- R3: Each channel evolves on its own: y_c = P(a, previous y_c) + x, where previous y_c is the last result of the same channel. Results of the other channel have no effect on it.
- R4: coef is signed with W-1 fraction bits (value coef/2^(W-1)). P(a,y) is the full signed product a*y plus 2^(W-2), arithmetically shifted right by W-1, and kept to its low W bits (rounding half toward plus infinity).
- R5: The sum P + x wraps modulo 2^W in two's complement and does not saturate.
- R6: The first sample accepted after reset carries in_chan = 0. Each accepted sample must carry the other tag than the previously accepted one, and the block sustains one accepted sample on every clock.
- R7: A valid sample whose tag differs from the expected one is dropped: it gives no output, leaves both channel states and the expected tag unchanged, and sets chan_err, which stays 1 until reset.
- R8: With in_valid = 0, the channel states and the expected tag do not change, and out_data keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset. It takes effect at once and is released in step with the clock |
| coef | input | W | Feedback coefficient, signed, W-1 fraction bits |
| in_valid | input | 1 | A sample is presented this clock |
| in_chan | input | 1 | Channel tag of the presented sample |
| in_data | input | W | Input sample, signed |
| out_valid | output | 1 | out_data holds a new result |
| out_chan | output | 1 | Channel tag of the result |
| out_data | output | W | Filter result, signed |
| chan_err | output | 1 | Sticky flag for a sample with the wrong channel tag |

## Verification
Two functions can act on the same edge: rejecting a mis-tagged sample, and freezing the loop so that the other channel's pending product is kept. The bench sends a wrong tag in the middle of a full-rate stream, right after a sample of the other channel. It checks that no result appears and that chan_err rises. The correctly tagged samples that follow must then give exactly the values that the bench's own model predicts, with the dropped sample removed. This is also how a gap made by idle clocks is judged, and it confirms that neither stall disturbs the product waiting between the multiplier and the adder.

// File: rtl/iir2_pkg.sv
package iir2_pkg;
  typedef enum logic {
    SLOT_CH0 = 1'b0,
    SLOT_CH1 = 1'b1
  } slot_e;

  function automatic slot_e slot_other(input slot_e s);
    return (s == SLOT_CH0) ? SLOT_CH1 : SLOT_CH0;
  endfunction
endpackage

// File: rtl/iir2_rst_sync.sv
module iir2_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/iir2_slot_check.sv
module iir2_slot_check
  import iir2_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_chan,
  output logic accept,
  output logic exp_chan,
  output logic chan_err
);
  slot_e exp_q, exp_d;
  logic  err_q, err_d;
  logic  mismatch;

  assign mismatch = (in_chan != logic'(exp_q));
  assign accept   = in_valid && !mismatch;

  always_comb begin
    exp_d = exp_q;
    err_d = err_q;
    if (accept)                exp_d = slot_other(exp_q);
    if (in_valid && mismatch)  err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q <= SLOT_CH0;
      err_q <= 1'b0;
    end else begin
      exp_q <= exp_d;
      err_q <= err_d;
    end
  end

  assign exp_chan = logic'(exp_q);
  assign chan_err = err_q;

  // R7: the error flag never clears without reset
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    chan_err |=> chan_err);

  // R6: an accepted sample hands the next slot to the other channel
  a_r6_turn_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_chan == exp_chan) |=> (exp_chan != $past(in_chan)));
endmodule

// File: rtl/iir2_coef_mul.sv
module iir2_coef_mul #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] coef_i,
  input  logic signed [W-1:0] y_i,
  output logic signed [W-1:0] p_o
);
  localparam int PW = 2 * W;
  localparam int SH = W - 1;
  localparam logic signed [PW-1:0] BIAS = PW'(1) <<< (W - 2);

  logic signed [PW-1:0] coef_ext;
  logic signed [PW-1:0] y_ext;

  assign coef_ext = PW'(coef_i);
  assign y_ext    = PW'(y_i);
  assign p_o      = W'(((coef_ext * y_ext) + BIAS) >>> SH);
endmodule

// File: rtl/iir2_loop.sv
module iir2_loop #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic signed [W-1:0] coef,
  input  logic signed [W-1:0] x_i,
  output logic signed [W-1:0] y_o
);
  logic signed [W-1:0] y_q, y_d;
  logic signed [W-1:0] p_q, p_d;
  logic signed [W-1:0] p_now;

  iir2_coef_mul #(.W(W)) u_mul (
    .coef_i (coef),
    .y_i    (y_q),
    .p_o    (p_now)
  );

  always_comb begin
    y_d = y_q;
    p_d = p_q;
    if (en) begin
      y_d = p_q + x_i;
      p_d = p_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q <= '0;
      p_q <= '0;
    end else begin
      y_q <= y_d;
      p_q <= p_d;
    end
  end

  assign y_o = y_q;

  // R8: a stalled slot leaves both loop registers untouched
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(y_q) && $stable(p_q)));
endmodule

// File: rtl/iir2_interleaved.sv
module iir2_interleaved #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] coef,
  input  logic         in_valid,
  input  logic         in_chan,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic         out_chan,
  output logic [W-1:0] out_data,
  output logic         chan_err
);
  logic rst_s_n;
  logic accept;
  logic exp_chan;
  logic vld_q, vld_d;
  logic tag_q, tag_d;
  logic signed [W-1:0] y_w;

  iir2_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  iir2_slot_check u_slot (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .in_valid (in_valid),
    .in_chan  (in_chan),
    .accept   (accept),
    .exp_chan (exp_chan),
    .chan_err (chan_err)
  );

  iir2_loop #(.W(W)) u_loop (
    .clk   (clk),
    .rst_n (rst_s_n),
    .en    (accept),
    .coef  (coef),
    .x_i   (in_data),
    .y_o   (y_w)
  );

  always_comb begin
    vld_d = accept;
    tag_d = tag_q;
    if (accept) tag_d = in_chan;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      vld_q <= 1'b0;
      tag_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      tag_q <= tag_d;
    end
  end

  assign out_valid = vld_q;
  assign out_chan  = tag_q;
  assign out_data  = y_w;

  // R2: a well-tagged sample yields a result tagged with its own channel
  a_r2_tag_follows: assert property (@(posedge clk) disable iff (!rst_s_n)
    (in_valid && in_chan == exp_chan) |=> (out_valid && out_chan == $past(in_chan)));

  // R7: a mis-tagged sample gives no result and raises the flag
  a_r7_reject_silent: assert property (@(posedge clk) disable iff (!rst_s_n)
    (in_valid && in_chan != exp_chan) |=> (!out_valid && chan_err && $stable(out_data)));
endmodule

// File: tb/tb_iir2_interleaved.sv
module tb_iir2_interleaved;
  localparam int W = 16;
  localparam time CLK_PERIOD = 10ns;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] coef;
  logic         in_valid;
  logic         in_chan;
  logic [W-1:0] in_data;
  logic         out_valid;
  logic         out_chan;
  logic [W-1:0] out_data;
  logic         chan_err;

  int checks;
  int errors;
  logic signed [W-1:0] ym [2];
  logic exp_ch;
  logic err_m;

  iir2_interleaved #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .coef(coef),
    .in_valid(in_valid), .in_chan(in_chan), .in_data(in_data),
    .out_valid(out_valid), .out_chan(out_chan), .out_data(out_data),
    .chan_err(chan_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic signed [W-1:0] rnd(input logic signed [W-1:0] a,
                                               input logic signed [W-1:0] y);
    longint p;
    p = longint'(a) * longint'(y);
    p = (p + (longint'(1) <<< (W-2))) >>> (W-1);
    return p[W-1:0];
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic signed [W-1:0] a);
    in_valid = 1'b0; in_chan = 1'b0; in_data = '0;
    coef = a;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    chk("R1", "out_valid in reset", longint'(out_valid), 0);
    chk("R1", "chan_err in reset", longint'(chan_err), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    ym[0] = '0; ym[1] = '0; exp_ch = 1'b0; err_m = 1'b0;
  endtask

  // one sample per call; calls back to back give a full-rate stream
  task automatic push(input logic ch, input logic signed [W-1:0] x, input string req);
    logic acc;
    logic signed [W-1:0] y_exp;
    @(negedge clk);
    in_valid = 1'b1; in_chan = ch; in_data = x;
    acc = (ch == exp_ch);
    y_exp = ym[ch];
    if (acc) begin
      y_exp = rnd(coef, ym[ch]) + x;
      ym[ch] = y_exp;
      exp_ch = ~exp_ch;
    end else begin
      err_m = 1'b1;
    end
    @(posedge clk);
    #(CLK_PERIOD/4);
    in_valid = 1'b0;
    chk(req, "out_valid", longint'(out_valid), longint'(acc));
    chk(req, "chan_err", longint'(chan_err), longint'(err_m));
    if (acc) begin
      chk(req, "out_chan", longint'(out_chan), longint'(ch));
      chk(req, "out_data", longint'($signed(out_data)), longint'(y_exp));
    end
  endtask

  task automatic idle(input int n, input string req);
    logic [W-1:0] held;
    held = out_data;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      chk(req, "out_valid idle", longint'(out_valid), 0);
      chk(req, "out_data held", longint'(out_data), longint'(held));
    end
  endtask

  task automatic t_reset_start;
    do_reset(16'sd16384);
    // R1: zero state, first result equals input
    push(1'b0, 16'sd1234, "R1");
    push(1'b1, -16'sd77, "R1");
  endtask

  task automatic t_basic;
    do_reset(16'sd24576); // 0.75
    for (int i = 0; i < 8; i++) begin
      push(1'b0, 16'(100 * (i + 1)), "R3");
      push(1'b1, 16'(-3000 + 17 * i), "R3");
    end
    // R2 latency / R6 alternation at full rate
    push(1'b0, 16'sd0, "R2");
    push(1'b1, 16'sd0, "R6");
  endtask

  task automatic t_round;
    do_reset(16'sd16384); // 0.5
    push(1'b0, 16'sd3, "R4");
    push(1'b1, -16'sd3, "R4");
    push(1'b0, 16'sd0, "R4");  // 1.5 -> 2
    push(1'b1, 16'sd0, "R4");  // -1.5 -> -1
    push(1'b0, 16'sd0, "R4");  // 1
    push(1'b1, 16'sd0, "R4");  // -0.5 -> 0
    do_reset(-16'sd32768);     // -1.0
    push(1'b0, 16'sd5, "R4");
    push(1'b1, 16'sd9, "R4");
    push(1'b0, 16'sd1, "R4");
    push(1'b1, 16'sd1, "R4");
  endtask

  task automatic t_wrap;
    do_reset(16'sd32767);
    for (int i = 0; i < 3; i++) begin
      push(1'b0, 16'sd30000, "R5");
      push(1'b1, -16'sd30000, "R5");
    end
  endtask

  task automatic t_idle;
    do_reset(16'sd20000);
    push(1'b0, 16'sd500, "R8");
    push(1'b1, 16'sd700, "R8");
    push(1'b0, 16'sd900, "R8");
    idle(5, "R8");
    push(1'b1, 16'sd11, "R8");
    idle(2, "R8");
    push(1'b0, 16'sd13, "R8");
    push(1'b1, 16'sd17, "R8");
  endtask

  task automatic t_wrong_tag;
    do_reset(-16'sd12000);
    // R7: wrong tag first after reset (channel 1 before channel 0)
    push(1'b1, 16'sd999, "R7");
    push(1'b0, 16'sd400, "R7");
    push(1'b1, 16'sd600, "R7");
    // R7: repeat of channel 1 mid-stream, back to back
    push(1'b1, 16'sd5555, "R7");
    push(1'b0, 16'sd40, "R7");
    push(1'b1, 16'sd60, "R7");
    push(1'b0, 16'sd0, "R7");
    push(1'b0, 16'sd321, "R7");
    push(1'b1, 16'sd0, "R7");
    idle(2, "R7");
    chk("R7", "chan_err sticky", longint'(chan_err), 1);
    do_reset(16'sd1000);
    chk("R1", "chan_err cleared", longint'(chan_err), 0);
  endtask

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_chan = 1'b0; in_data = '0; coef = '0;
    t_reset_start();
    t_basic();
    t_round();
    t_wrap();
    t_idle();
    t_wrong_tag();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule